// File: doc/BRIEF.md
# I2C Stuck-Bus Recovery Sequencer

This block frees a two-wire bus when a target device has been left holding the data line low, typically after a transfer was cut short in the middle of a byte. Software first looks at the live clock and data levels, which the block brings out after synchronisation. If data is low while clock is high, software pulses the recovery command. The sequencer then clocks the bus by pulling the clock line low and releasing it, a bounded number of times. After every released (high) clock phase it samples the data line. As soon as data reads high it issues a STOP condition and raises the done flag. If data never comes free, it lets go of both lines and raises the fail flag.

A watchdog counts ticks of a slow base clock while a recovery is running, and it aborts the attempt with the fail flag once a limit is reached. Both flags are sticky. Software clears them by writing ones to their bit positions. The pins are open drain: the block only ever asks for a line to be pulled low, and the pad or bench resolves the bus level.

The state machine has six states:
- IDLE: nothing is driven. `recover_cmd` takes it to PULSE_LO.
- PULSE_LO: the clock line is pulled low for one half phase, then PULSE_HI follows.
- PULSE_HI: the clock line is released for one half phase. At its end, data high leads to STOP_LO. Data still low on the last permitted pulse leads to IDLE with fail. Otherwise PULSE_LO follows.
- STOP_LO: clock and data are both pulled low, then STOP_HI follows.
- STOP_HI: clock is released while data is held low, then STOP_REL follows.
- STOP_REL: both lines are released, then IDLE with done.

From any state other than IDLE, a watchdog expiry leads to IDLE with fail.

Top module: `i2c_bus_unstick`

## Requirements
- R1: `line_scl` and `line_sda` show the bus clock and data levels after SYNC_STAGES clock cycles of synchronisation. Both read 1 after reset.
- R2: A `recover_cmd` accepted in IDLE causes `scl_drive_low` to be 1 in the first cycle afterwards. Every low and high clock phase lasts exactly HALF_CYCLES cycles.
- R3: The data level is sampled at the end of each high phase, and pulsing stops at the first sample that reads high. A successful recovery gives one pulse if data was already free. Otherwise it gives as many pulses as the target needs, up to MAX_PULSES.
- R4: STOP is generated as three half phases in order: clock and data both low, then clock released with data low, then both released. After that `recov_done` (interrupt bit 0) is set.
- R5: If data still reads low after MAX_PULSES pulses, both lines are released and `recov_fail` (interrupt bit 1) is set, with no STOP.
- R6: While busy, the block counts cycles with `base_tick` high, starting from 0 at the command. Once the count has reached TIMEOUT_TICKS, the next cycle aborts to IDLE with both lines released and `recov_fail` set.
- R7: `recover_cmd` has no effect while a recovery is running.
- R8: The flags are sticky. A cycle with `irq_clr_we` high clears each flag whose `irq_clr` bit is 1 (bit 0 done, bit 1 fail). A set in the same cycle takes precedence. Writing 2'b11 clears both flags.
- R9: The data line is never pulled low during the clocking phases. It only starts being driven while the clock is also driven low.
- R10: `busy` is 1 from the cycle after an accepted command until the cycle the done or fail flag is set, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| recover_cmd | input | 1 | Start a recovery (one-cycle pulse) |
| irq_clr_we | input | 1 | Write strobe for flag clearing |
| irq_clr | input | 2 | Write-one-to-clear mask: bit 0 done, bit 1 fail |
| base_tick | input | 1 | One-cycle enable from the slow base clock |
| scl_in | input | 1 | Resolved bus clock level |
| sda_in | input | 1 | Resolved bus data level |
| scl_drive_low | output | 1 | Pull the clock line low |
| sda_drive_low | output | 1 | Pull the data line low |
| line_scl | output | 1 | Synchronised clock level |
| line_sda | output | 1 | Synchronised data level |
| busy | output | 1 | Recovery in progress |
| recov_done | output | 1 | Sticky recovery-success flag |
| recov_fail | output | 1 | Sticky recovery-failure flag |

## Verification
The bench builds the block with HALF_CYCLES=4, MAX_PULSES=9, TIMEOUT_TICKS=6 and two synchroniser stages. With these values a full nine-pulse failure takes only 72 cycles, so the pulse-limit boundary can be reached on both sides: release on the ninth pulse and on the tenth. With the base tick pulsed every third cycle, the watchdog abort arrives long before the pulse limit, while runs with the tick held low never time out. A target model that frees data after a chosen number of clock falling edges covers release counts of 0, 2, 3, 9 and 10, and a command re-issued while a recovery is running.

// File: rtl/unstick_pkg.sv
package unstick_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_PULSE_LO,
        S_PULSE_HI,
        S_STOP_LO,
        S_STOP_HI,
        S_STOP_REL
    } seq_state_t;
endpackage

// File: rtl/unstick_sync.sv
module unstick_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[s] <= '1;
                else        chain[s] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[s] <= '1;
                else        chain[s] <= chain[s-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/unstick_phase_timer.sv
module unstick_phase_timer #(
    parameter int HALF_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic expire
);
    localparam int CW = (HALF_CYCLES > 2) ? $clog2(HALF_CYCLES) : 1;

    logic [CW-1:0] remain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              remain <= '0;
        else if (load)           remain <= CW'(HALF_CYCLES - 1);
        else if (remain != '0)   remain <= remain - 1'b1;
    end

    assign expire = (remain == '0);

    AST_PHASE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        remain <= CW'(HALF_CYCLES - 1)); // R2
endmodule

// File: rtl/unstick_watchdog.sv
module unstick_watchdog #(
    parameter int LIMIT = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic active,
    input  logic tick,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] ticks;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                            ticks <= '0;
        else if (clear)                        ticks <= '0;
        else if (active && tick && !expired)   ticks <= ticks + 1'b1;
    end

    assign expired = (ticks == CW'(LIMIT));

    AST_TICK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        ticks <= CW'(LIMIT)); // R6
endmodule

// File: rtl/i2c_bus_unstick.sv
module i2c_bus_unstick #(
    parameter int HALF_CYCLES   = 250,
    parameter int MAX_PULSES    = 9,
    parameter int TIMEOUT_TICKS = 200,
    parameter int SYNC_STAGES   = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       recover_cmd,
    input  logic       irq_clr_we,
    input  logic [1:0] irq_clr,
    input  logic       base_tick,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       scl_drive_low,
    output logic       sda_drive_low,
    output logic       line_scl,
    output logic       line_sda,
    output logic       busy,
    output logic       recov_done,
    output logic       recov_fail
);
    import unstick_pkg::*;

    localparam int PW = $clog2(MAX_PULSES + 1);

    seq_state_t    state, state_nx;
    logic [1:0]    lines_s;
    logic          phase_load, phase_done;
    logic          start_take, pulse_inc, set_ok, set_fail;
    logic          timed_out;
    logic [PW-1:0] pulse_cnt;

    unstick_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({scl_in, sda_in}),
        .q     (lines_s)
    );
    assign line_scl = lines_s[1];
    assign line_sda = lines_s[0];

    unstick_phase_timer #(.HALF_CYCLES(HALF_CYCLES)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (phase_load),
        .expire (phase_done)
    );

    unstick_watchdog #(.LIMIT(TIMEOUT_TICKS)) u_wdog (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (start_take),
        .active  (busy),
        .tick    (base_tick),
        .expired (timed_out)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // Next-state and event decode
    always_comb begin
        state_nx   = state;
        phase_load = 1'b0;
        start_take = 1'b0;
        pulse_inc  = 1'b0;
        set_ok     = 1'b0;
        set_fail   = 1'b0;
        unique case (state)
            S_IDLE: begin
                if (recover_cmd) begin
                    state_nx   = S_PULSE_LO;
                    phase_load = 1'b1;
                    start_take = 1'b1;
                end
            end
            S_PULSE_LO: begin
                if (phase_done) begin
                    state_nx   = S_PULSE_HI;
                    phase_load = 1'b1;
                end
            end
            S_PULSE_HI: begin
                if (phase_done) begin
                    pulse_inc = 1'b1;
                    if (line_sda) begin
                        state_nx   = S_STOP_LO;
                        phase_load = 1'b1;
                    end else if (pulse_cnt == PW'(MAX_PULSES - 1)) begin
                        state_nx = S_IDLE;
                        set_fail = 1'b1;
                    end else begin
                        state_nx   = S_PULSE_LO;
                        phase_load = 1'b1;
                    end
                end
            end
            S_STOP_LO: begin
                if (phase_done) begin
                    state_nx   = S_STOP_HI;
                    phase_load = 1'b1;
                end
            end
            S_STOP_HI: begin
                if (phase_done) begin
                    state_nx   = S_STOP_REL;
                    phase_load = 1'b1;
                end
            end
            S_STOP_REL: begin
                if (phase_done) begin
                    state_nx = S_IDLE;
                    set_ok   = 1'b1;
                end
            end
            default: state_nx = S_IDLE;
        endcase
        if (state != S_IDLE && timed_out) begin
            state_nx   = S_IDLE;
            set_ok     = 1'b0;
            set_fail   = 1'b1;
            phase_load = 1'b0;
            pulse_inc  = 1'b0;
        end
    end

    // Output decode
    always_comb begin
        scl_drive_low = 1'b0;
        sda_drive_low = 1'b0;
        unique case (state)
            S_PULSE_LO: scl_drive_low = 1'b1;
            S_STOP_LO: begin
                scl_drive_low = 1'b1;
                sda_drive_low = 1'b1;
            end
            S_STOP_HI:  sda_drive_low = 1'b1;
            default: ;
        endcase
    end
    assign busy = (state != S_IDLE);

    // Pulse counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          pulse_cnt <= '0;
        else if (start_take) pulse_cnt <= '0;
        else if (pulse_inc)  pulse_cnt <= pulse_cnt + 1'b1;
    end

    // Sticky flags, write-one-to-clear, set wins
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            recov_done <= 1'b0;
            recov_fail <= 1'b0;
        end else begin
            recov_done <= set_ok   | (recov_done & ~(irq_clr_we & irq_clr[0]));
            recov_fail <= set_fail | (recov_fail & ~(irq_clr_we & irq_clr[1]));
        end
    end

    AST_PULSE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_cnt <= PW'(MAX_PULSES)); // R3
    AST_DONE_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(recov_done) |-> $past(busy) && !busy); // R4
    AST_STOP_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_drive_low) && busy |-> !scl_drive_low); // R4
    AST_FAIL_NO_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(recov_fail) && !$past(timed_out) |-> !$past(sda_drive_low)); // R5
    AST_TIMEOUT_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        busy && timed_out |=> !busy && recov_fail); // R6
    AST_SDA_WITH_SCL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_drive_low) |-> scl_drive_low); // R9
endmodule

// File: tb/i2c_bus_unstick_test.sv
module i2c_bus_unstick_test;
    localparam int CLK_PERIOD = 10;
    localparam int H    = 4;
    localparam int MAXP = 9;
    localparam int TO   = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic recover_cmd = 1'b0;
    logic irq_clr_we = 1'b0;
    logic [1:0] irq_clr = 2'b00;
    logic base_tick = 1'b0;
    logic force_scl_low = 1'b0;
    logic scl_drive_low, sda_drive_low, line_scl, line_sda, busy, recov_done, recov_fail;
    logic scl_bus, sda_bus;

    int errors = 0;
    int checks = 0;
    int tick_period = 0;
    int cyc = 0;
    int tgt_k = 0;
    int tgt_edges = 0;
    bit cmp_en = 0;
    bit finished = 0;
    bit sda_seen_drive = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign scl_bus = !(scl_drive_low || force_scl_low);
    assign sda_bus = !(sda_drive_low || (tgt_edges < tgt_k));

    always @(negedge scl_bus) tgt_edges = tgt_edges + 1;

    i2c_bus_unstick #(.HALF_CYCLES(H), .MAX_PULSES(MAXP), .TIMEOUT_TICKS(TO), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst_n(rst_n), .recover_cmd(recover_cmd), .irq_clr_we(irq_clr_we),
        .irq_clr(irq_clr), .base_tick(base_tick), .scl_in(scl_bus), .sda_in(sda_bus),
        .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low), .line_scl(line_scl),
        .line_sda(line_sda), .busy(busy), .recov_done(recov_done), .recov_fail(recov_fail)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Behavioural reference model
    bit m_busy = 0, m_done = 0, m_fail = 0;
    int m_n = 0, m_p = 0, m_ticks = 0;

    always @(posedge clk) begin
        bit s_ok, s_fail;
        s_ok = 0; s_fail = 0;
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_fail = 0; m_n = 0; m_ticks = 0;
        end else begin
            if (m_busy) begin
                if (m_ticks == TO) begin
                    m_busy = 0; s_fail = 1;
                end else begin
                    if (base_tick) m_ticks++;
                    m_n++;
                    if (m_p > 0 && m_n == 2*H*m_p + 3*H) begin m_busy = 0; s_ok = 1; end
                    else if (m_p == 0 && m_n == 2*H*MAXP) begin m_busy = 0; s_fail = 1; end
                end
            end else if (recover_cmd) begin
                m_busy = 1; m_n = 0; m_ticks = 0;
                m_p = (tgt_k > MAXP) ? 0 : ((tgt_k == 0) ? 1 : tgt_k);
            end
            m_done = s_ok   | (m_done && !(irq_clr_we && irq_clr[0]));
            m_fail = s_fail | (m_fail && !(irq_clr_we && irq_clr[1]));
        end
    end

    always @(negedge clk) begin
        int e_scl, e_sda, r;
        cyc++;
        base_tick <= (tick_period != 0) && (cyc % tick_period == 0);
        if (sda_drive_low) sda_seen_drive = 1;
        if (cmp_en) begin
            e_scl = 0; e_sda = 0;
            if (m_busy) begin
                if (m_p == 0 || m_n < 2*H*m_p) e_scl = ((m_n % (2*H)) < H);
                else begin
                    r = m_n - 2*H*m_p;
                    e_scl = (r < H);
                    e_sda = (r < 2*H);
                end
            end
            chk("R2 scl_drive_low", scl_drive_low, e_scl);
            chk("R4 sda_drive_low", sda_drive_low, e_sda);
            chk("R10 busy", busy, m_busy);
            chk("R8 recov_done", recov_done, m_done);
            chk("R8 recov_fail", recov_fail, m_fail);
        end
    end

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_flags(input logic [1:0] m);
        @(negedge clk); irq_clr_we = 1'b1; irq_clr = m;
        @(negedge clk); irq_clr_we = 1'b0; irq_clr = 2'b00;
    endtask

    task automatic arm(input int k);
        @(negedge clk);
        tgt_edges = 0; tgt_k = k; sda_seen_drive = 0;
    endtask

    task automatic start_cmd();
        @(negedge clk); recover_cmd = 1'b1;
        @(negedge clk); recover_cmd = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 400 && busy; i++) @(negedge clk);
    endtask

    initial begin
        cycles(3);
        rst_n = 1'b1;
        cmp_en = 1;
        cycles(2);
        chk("R1 line_scl after reset", line_scl, 1);
        chk("R1 line_sda after reset", line_sda, 1);
        chk("R10 busy after reset", busy, 0);

        // R1: stuck data visible in status
        arm(99);
        cycles(3);
        chk("R1 line_sda stuck", line_sda, 0);
        chk("R1 line_scl high", line_scl, 1);
        force_scl_low = 1'b1;
        cycles(3);
        chk("R1 line_scl forced low", line_scl, 0);
        force_scl_low = 1'b0;
        cycles(3);

        // R3: data frees after 3 clocks
        arm(3);
        start_cmd();
        wait_idle();
        chk("R3 falling edges k=3", tgt_edges, 4);
        chk("R4 done after k=3", recov_done, 1);
        chk("R1 line_sda released", line_sda, 1);
        clear_flags(2'b11);
        chk("R8 clear all", recov_done, 0);

        // R3: data already free, one pulse
        arm(0);
        start_cmd();
        wait_idle();
        chk("R3 falling edges k=0", tgt_edges, 2);
        chk("R4 done k=0", recov_done, 1);

        // R3: boundary, release on the last pulse
        arm(9);
        start_cmd();
        wait_idle();
        chk("R3 falling edges k=9", tgt_edges, 10);
        chk("R4 done k=9", recov_done, 1);
        chk("R5 no fail k=9", recov_fail, 0);
        clear_flags(2'b11);

        // R5: one beyond the limit
        arm(10);
        start_cmd();
        wait_idle();
        chk("R5 falling edges k=10", tgt_edges, 9);
        chk("R5 fail set", recov_fail, 1);
        chk("R5 done clear", recov_done, 0);
        chk("R9 sda never driven in pulsing", sda_seen_drive, 0);
        chk("R5 scl released", scl_drive_low, 0);

        // R8: partial clear leaves fail
        clear_flags(2'b01);
        chk("R8 partial clear keeps fail", recov_fail, 1);
        clear_flags(2'b11);
        chk("R8 fail cleared", recov_fail, 0);

        // R7: command while busy ignored
        arm(2);
        start_cmd();
        cycles(5);
        start_cmd();
        wait_idle();
        cycles(6);
        chk("R7 no restart busy", busy, 0);
        chk("R7 edges", tgt_edges, 3);
        clear_flags(2'b11);

        // R6: watchdog abort
        tick_period = 3;
        arm(99);
        start_cmd();
        wait_idle();
        chk("R6 fail on timeout", recov_fail, 1);
        chk("R6 aborted before limit", (tgt_edges < MAXP) ? 1 : 0, 1);
        chk("R6 lines released", scl_drive_low + sda_drive_low, 0);
        tick_period = 0;
        clear_flags(2'b11);
        arm(0);
        cycles(4);

        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            errors++; checks++;
            $display("FAIL R10 watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule